// File: doc/BRIEF.md
# Multiplexed Segment LCD Drive Sequencer

This block produces the time-sliced drive pattern for a passive segment LCD with one to eight common lines. On every enable pulse from a slow display clock it walks through the active commons one time slot at a time. For each common line and each segment line it outputs a two-bit code that selects one of four bias rails. Code 0 is the lowest rail, code 1 is one third, code 2 is two thirds and code 3 is the full rail. An analog stage outside the block turns these codes into voltages. The pixel bitmap, the duty select, a prescale value and the polarity scheme come from configuration held elsewhere.

The polarity scheme decides where the drive inverts so that no pixel sees a net DC voltage. In slot-inverting operation each common slot has two halves of opposite polarity, so every frame is balanced on its own. In frame-inverting operation the polarity holds for a whole frame and flips for the next one, so a frame pair is balanced. New duty, prescale or scheme values are loaded only at a balanced point. A sleep request is honoured only at such a point, after which every line is parked on code 0.

The controller is a three-state machine. IDLE drives code 0 everywhere and waits for the first enable. RUN sweeps the commons. SLEEP parks the outputs and raises the acknowledge. The transitions are: IDLE to SLEEP when a sleep request is present; IDLE to RUN on an enable pulse with no request; RUN to SLEEP at a balanced boundary with a request pending or present; SLEEP to IDLE when the request is withdrawn.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: While reset is asserted, and in IDLE after it, every COM and SEG code is 0 and both `frame_strobe` and `sleep_ack` are 0.
- R2: `mux_sel` value m selects N = m+1 commons. The factor K is 4 for m=0, 2 for m=1 and 1 otherwise. Each common slot has two halves of K·(prescale+1) enable pulses, so a frame lasts 2·K·N·(prescale+1) pulses. `frame_strobe` is high for exactly the one clock after the edge that takes the last pulse of a frame.
- R3: In RUN the commons are active one at a time, COM0 up to COM(N-1), one per slot. The active common drives code 3 at polarity 0 and code 0 at polarity 1. In multiplexed modes (m≠0) every other common, including the unused ones, drives the mid code: 1 at polarity 0, 2 at polarity 1.
- R4: SEG line s reads pixel bit `pixels[c*NSEG + s]`, where c is the active common. A set bit (dark) drives code 0 at polarity 0 and code 3 at polarity 1. A clear bit drives code 2 at polarity 0 and code 1 at polarity 1 in multiplexed modes.
- R5: In static mode (m=0), COM0 alternates between codes 3 and 0 and all other commons drive code 0. A clear segment drives the same code as COM0.
- R6: With `wave_b`=0, polarity is 0 in the first half of every slot and 1 in the second half.
- R7: With `wave_b`=1, polarity is constant within a frame. It is 0 in the first frame after RUN is entered or after a reload, and it toggles at every frame end.
- R8: `mux_sel`, `prescale` and `wave_b` are taken in on entry to RUN and otherwise only at a balanced boundary. That boundary is every frame end when `wave_b`=0, and the end of the second frame of a pair when `wave_b`=1.
- R9: A sleep request seen at any clock in RUN is latched and taken at the next balanced boundary. `sleep_ack` stays high, with every code 0, until the request drops. The block then returns to IDLE and restarts at COM0 with polarity 0 on the next enable.
- R10: Counters advance only on clocks where `lcd_tick` is high. Clocks without an enable leave every output code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lcd_tick | input | 1 | One-clock enable pulse from the slow display clock |
| mux_sel | input | MUX_W | Duty select: 0 static, m gives m+1 commons |
| prescale | input | PRE_W | Frame prescale value |
| wave_b | input | 1 | 0 = invert within each slot, 1 = invert per frame |
| pixels | input | NCOM*NSEG | Pixel bitmap, bit c*NSEG+s for common c, segment s |
| sleep_req | input | 1 | Request to park the display |
| com_lvl | output | 2*NCOM | Rail code per common line, line i at bits 2i+1:2i |
| seg_lvl | output | 2*NSEG | Rail code per segment line, line s at bits 2s+1:2s |
| frame_strobe | output | 1 | One-clock pulse after each frame ends |
| sleep_ack | output | 1 | High while parked |

## Verification
A behavioural model tracks the position within a frame or frame pair as a single pulse count and derives the expected common, half and polarity from it. The design's outputs are compared against this model on every clock. The sweep is tried in static mode, 1/2 duty with frame inversion, 1/4 duty with slot inversion and 1/8 duty with frame inversion and a larger prescale. These cases separate the K factor, the slot length, the choice of inversion scheme and the pixel row selection. Further runs change the configuration part way through a frame, request sleep in each scheme and use sparse enable pulses. These show whether reloads, sleep entry and advancing wait for the correct boundary or pulse.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLEEP = 2'd2
    } seq_state_t;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LV_0 = 2'd0;
    localparam lvl_t LV_1 = 2'd1;
    localparam lvl_t LV_2 = 2'd2;
    localparam lvl_t LV_3 = 2'd3;
endpackage

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
    import lcd_seq_pkg::*;
#(
    parameter int MUX_W = 3,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [MUX_W-1:0] mux_sel,
    input  logic [PRE_W-1:0] prescale,
    input  logic             wave_b,
    input  logic             sleep_req,
    output seq_state_t       state_o,
    output logic [MUX_W-1:0] mux_o,
    output logic [MUX_W-1:0] cidx_o,
    output logic             pol_o,
    output logic             strobe_o
);
    localparam int CNT_W = PRE_W + 3;

    seq_state_t       st_q, st_d;
    logic [MUX_W-1:0] mux_q, cidx_q;
    logic [PRE_W-1:0] lp_q;
    logic             b_q, half_q, fpar_q, pend_q, strobe_q;
    logic [CNT_W-1:0] pcnt_q, lim;
    logic [1:0]       ksh;
    logic             slot_last, frm_last, bnd, go_sleep, load_run;

    always_comb begin
        ksh       = (mux_q == '0) ? 2'd2 : ((mux_q == MUX_W'(1)) ? 2'd1 : 2'd0);
        lim       = (CNT_W'(lp_q) + CNT_W'(1)) << ksh;
        slot_last = (st_q == ST_RUN) && tick && (pcnt_q == lim - CNT_W'(1));
        frm_last  = slot_last && half_q && (cidx_q == mux_q);
        bnd       = frm_last && (!b_q || fpar_q);
        go_sleep  = bnd && (pend_q || sleep_req);
        load_run  = (st_q == ST_IDLE) && !sleep_req && tick;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (sleep_req) st_d = ST_SLEEP;
                      else if (tick) st_d = ST_RUN;
            ST_RUN:   if (go_sleep) st_d = ST_SLEEP;
            ST_SLEEP: if (!sleep_req) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mux_q    <= '0;
            lp_q     <= '0;
            b_q      <= 1'b0;
            pcnt_q   <= '0;
            half_q   <= 1'b0;
            cidx_q   <= '0;
            fpar_q   <= 1'b0;
            pend_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= frm_last;
            if (st_q != ST_RUN) begin
                pcnt_q <= '0;
                half_q <= 1'b0;
                cidx_q <= '0;
                fpar_q <= 1'b0;
                pend_q <= 1'b0;
                if (load_run) begin
                    mux_q <= mux_sel;
                    lp_q  <= prescale;
                    b_q   <= wave_b;
                end
            end else begin
                pend_q <= bnd ? 1'b0 : (pend_q || sleep_req);
                if (tick) begin
                    if (slot_last) begin
                        pcnt_q <= '0;
                        half_q <= ~half_q;
                        if (half_q) cidx_q <= frm_last ? '0 : cidx_q + MUX_W'(1);
                        if (frm_last) fpar_q <= ~fpar_q;
                        if (bnd) begin
                            fpar_q <= 1'b0;
                            mux_q  <= mux_sel;
                            lp_q   <= prescale;
                            b_q    <= wave_b;
                        end
                    end else begin
                        pcnt_q <= pcnt_q + CNT_W'(1);
                    end
                end
            end
        end
    end

    assign state_o  = st_q;
    assign mux_o    = mux_q;
    assign cidx_o   = cidx_q;
    assign pol_o    = b_q ? fpar_q : half_q;
    assign strobe_o = strobe_q;

    // R8: configuration only moves at a balanced boundary
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && $past(st_q == ST_RUN) && !$past(bnd))
            |-> ($stable(mux_q) && $stable(lp_q) && $stable(b_q)));
    // R3: the active common never passes N-1
    a_r3_cidx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (cidx_q <= mux_q));
    // R2: frame strobe is a single-clock pulse
    a_r2_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q);
    // R9: sleep is entered only from IDLE or at a balanced boundary
    a_r9_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == ST_SLEEP) |-> ($past(st_q == ST_IDLE) || $past(bnd)));
endmodule

// File: rtl/lcd_drive_map.sv
module lcd_drive_map
    import lcd_seq_pkg::*;
#(
    parameter int NCOM  = 8,
    parameter int NSEG  = 4,
    parameter int MUX_W = 3
) (
    input  logic                 run,
    input  logic [MUX_W-1:0]     mux,
    input  logic [MUX_W-1:0]     cidx,
    input  logic                 pol,
    input  logic [NCOM*NSEG-1:0] pixels,
    output logic [2*NCOM-1:0]    com_lvl,
    output logic [2*NSEG-1:0]    seg_lvl
);
    logic            is_static;
    lvl_t            act_lv, idle_lv, dark_lv, clr_lv;
    logic [NSEG-1:0] row;

    always_comb begin
        is_static = (mux == '0);
        act_lv    = pol ? LV_0 : LV_3;
        idle_lv   = is_static ? LV_0 : (pol ? LV_2 : LV_1);
        dark_lv   = pol ? LV_3 : LV_0;
        clr_lv    = is_static ? act_lv : (pol ? LV_1 : LV_2);
        row       = pixels[int'(cidx)*NSEG +: NSEG];
    end

    for (genvar gc = 0; gc < NCOM; gc++) begin : g_com
        assign com_lvl[2*gc +: 2] = !run ? LV_0 :
                                    ((cidx == MUX_W'(gc)) ? act_lv : idle_lv);
    end

    for (genvar gs = 0; gs < NSEG; gs++) begin : g_seg
        assign seg_lvl[2*gs +: 2] = !run ? LV_0 : (row[gs] ? dark_lv : clr_lv);
    end
endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
    import lcd_seq_pkg::*;
#(
    parameter int NSEG  = 4,
    parameter int MUX_W = 3,
    parameter int PRE_W = 4,
    localparam int NCOM = 1 << MUX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lcd_tick,
    input  logic [MUX_W-1:0]     mux_sel,
    input  logic [PRE_W-1:0]     prescale,
    input  logic                 wave_b,
    input  logic [NCOM*NSEG-1:0] pixels,
    input  logic                 sleep_req,
    output logic [2*NCOM-1:0]    com_lvl,
    output logic [2*NSEG-1:0]    seg_lvl,
    output logic                 frame_strobe,
    output logic                 sleep_ack
);
    seq_state_t       st;
    logic [MUX_W-1:0] mux_q, cidx;
    logic             pol;

    lcd_seq_ctrl #(.MUX_W(MUX_W), .PRE_W(PRE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(lcd_tick), .mux_sel(mux_sel),
        .prescale(prescale), .wave_b(wave_b), .sleep_req(sleep_req),
        .state_o(st), .mux_o(mux_q), .cidx_o(cidx), .pol_o(pol),
        .strobe_o(frame_strobe)
    );

    lcd_drive_map #(.NCOM(NCOM), .NSEG(NSEG), .MUX_W(MUX_W)) u_map (
        .run(st == ST_RUN), .mux(mux_q), .cidx(cidx), .pol(pol),
        .pixels(pixels), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    assign sleep_ack = (st == ST_SLEEP);

    logic [NCOM-1:0] com_full;
    for (genvar gi = 0; gi < NCOM; gi++) begin : g_full
        assign com_full[gi] = (com_lvl[2*gi +: 2] == LV_0) || (com_lvl[2*gi +: 2] == LV_3);
    end

    // R3: exactly one common at a full rail in multiplexed operation
    a_r3_one_active: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && mux_q != '0) |-> ($countones(com_full) == 1));
    // R9: parked outputs give zero volts across every pixel
    a_r9_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ack |-> (com_lvl == '0 && seg_lvl == '0));
    // R1: nothing is driven before RUN
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (com_lvl == '0 && seg_lvl == '0 && !frame_strobe));
endmodule

// File: tb/sim_lcd_mux_sequencer.sv
module sim_lcd_mux_sequencer;
    localparam int NSEG = 4, MUX_W = 3, PRE_W = 4, NCOM = 8;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wave_b = 1'b0, sleep_req = 1'b0;
    logic [MUX_W-1:0] mux_sel = '0;
    logic [PRE_W-1:0] prescale = '0;
    logic [NCOM*NSEG-1:0] pixels = 32'h0;
    logic [2*NCOM-1:0] com_lvl;
    logic [2*NSEG-1:0] seg_lvl;
    logic frame_strobe, sleep_ack;

    lcd_mux_sequencer #(.NSEG(NSEG), .MUX_W(MUX_W), .PRE_W(PRE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lcd_tick(tick), .mux_sel(mux_sel),
        .prescale(prescale), .wave_b(wave_b), .pixels(pixels),
        .sleep_req(sleep_req), .com_lvl(com_lvl), .seg_lvl(seg_lvl),
        .frame_strobe(frame_strobe), .sleep_ack(sleep_ack)
    );

    always #5 clk = ~clk;

    int    n_chk = 0, n_bad = 0, tick_div = 1, cyc = 0;
    string phase = "R1";
    bit    done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] act=%h exp=%h", tag, phase, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        cyc++;
        tick = (tick_div <= 1) || (cyc % tick_div == 0);
    end

    // behavioural model: position counted in pulses since frame (pair) start
    int m_st, m_tpos, m_mux, m_lp;
    bit m_b, m_pend, m_strobe;

    function automatic int kf(input int m);
        return (m == 0) ? 4 : ((m == 1) ? 2 : 1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_tpos = 0; m_mux = 0; m_lp = 0;
            m_b = 0; m_pend = 0; m_strobe = 0;
        end else begin
            m_strobe = 0;
            case (m_st)
                0: if (sleep_req) m_st = 2;
                   else if (tick) begin
                       m_st = 1; m_tpos = 0;
                       m_mux = int'(mux_sel); m_lp = int'(prescale); m_b = wave_b;
                   end
                1: begin
                    automatic bit reqn = m_pend || sleep_req;
                    automatic bit bnd = 0;
                    if (tick) begin
                        automatic int len = kf(m_mux) * (m_lp + 1);
                        automatic int fl = 2 * (m_mux + 1) * len;
                        m_tpos++;
                        if (m_tpos % fl == 0) m_strobe = 1;
                        if (m_tpos == (m_b ? 2 * fl : fl)) begin
                            bnd = 1; m_tpos = 0;
                            m_mux = int'(mux_sel); m_lp = int'(prescale); m_b = wave_b;
                        end
                    end
                    if (bnd && reqn) begin m_st = 2; m_pend = 0; end
                    else m_pend = bnd ? 1'b0 : reqn;
                end
                default: if (!sleep_req) m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic logic [2*NCOM-1:0] ec = '0;
            automatic logic [2*NSEG-1:0] es = '0;
            if (m_st == 1) begin
                automatic int len = kf(m_mux) * (m_lp + 1);
                automatic int fl = 2 * (m_mux + 1) * len;
                automatic int fp = m_tpos % fl;
                automatic int c = fp / (2 * len);
                automatic int h = (fp / len) % 2;
                automatic int p = m_b ? int'(m_tpos >= fl) : h;
                for (int i = 0; i < NCOM; i++) begin
                    if (m_mux == 0) ec[2*i +: 2] = (i == 0) ? (p ? 2'd0 : 2'd3) : 2'd0;
                    else            ec[2*i +: 2] = (i == c) ? (p ? 2'd0 : 2'd3) : (p ? 2'd2 : 2'd1);
                end
                for (int s = 0; s < NSEG; s++) begin
                    if (pixels[c*NSEG + s]) es[2*s +: 2] = p ? 2'd3 : 2'd0;
                    else if (m_mux == 0)    es[2*s +: 2] = p ? 2'd0 : 2'd3;
                    else                    es[2*s +: 2] = p ? 2'd1 : 2'd2;
                end
            end
            check(com_lvl == ec, (m_mux == 0) ? "R5" : "R3", 32'(com_lvl), 32'(ec));
            check(seg_lvl == es, "R4", 32'(seg_lvl), 32'(es));
            check(frame_strobe == m_strobe, "R2", 32'(frame_strobe), 32'(m_strobe));
            check(sleep_ack == (m_st == 2), "R9", 32'(sleep_ack), 32'(m_st == 2));
        end
    end

    task automatic run_phase(input string tag, input int m, input int lp, input bit b, input int n);
        @(posedge clk); #3;
        phase = tag; mux_sel = MUX_W'(m); prescale = PRE_W'(lp); wave_b = b;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #3;
            if (k % 29 == 0) pixels = $urandom;
        end
    endtask

    task automatic do_sleep(input string tag);
        int waited = 0;
        @(posedge clk); #3;
        phase = tag; sleep_req = 1'b1;
        while (!sleep_ack && waited < 3000) begin @(posedge clk); #3; waited++; end
        check(sleep_ack == 1'b1, "R9", 32'(sleep_ack), 32'd1);
        check(com_lvl == '0 && seg_lvl == '0, "R9", {com_lvl, 8'h0, seg_lvl}, 32'h0);
        repeat (12) begin @(posedge clk); #3; end
        sleep_req = 1'b0;
        repeat (250) begin @(posedge clk); #3; end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog [%s] act=0 exp=1", phase);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        pixels = 32'hA5C3_1E7B;
        repeat (3) @(posedge clk);
        #3;
        check(com_lvl == '0 && seg_lvl == '0, "R1", {com_lvl, 8'h0, seg_lvl}, 32'h0);
        check(!frame_strobe && !sleep_ack, "R1", {30'h0, frame_strobe, sleep_ack}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(com_lvl == '0 && seg_lvl == '0, "R1", {com_lvl, 8'h0, seg_lvl}, 32'h0);
        run_phase("R5 static", 0, 0, 1'b0, 200);
        run_phase("R6 quarter", 3, 1, 1'b0, 400);
        run_phase("R7 half", 1, 0, 1'b1, 300);
        run_phase("R7 eighth", 7, 2, 1'b1, 700);
        run_phase("R8 reload A", 2, 0, 1'b0, 37);
        run_phase("R8 reload A", 5, 3, 1'b0, 600);
        run_phase("R8 reload B", 4, 1, 1'b1, 500);
        do_sleep("R9 sleep B");
        run_phase("R9 resume", 2, 1, 1'b0, 45);
        do_sleep("R9 sleep A");
        tick_div = 3;
        run_phase("R10 sparse", 4, 1, 1'b0, 700);
        run_phase("R10 sparse B", 1, 2, 1'b1, 500);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule